// File: doc/BRIEF.md
# Serial Port Host Register and Interrupt Identification Logic

This block is the register file and interrupt controller that sits between a host bus and the data path of a 16550-compatible serial port. The host selects one of eight byte registers with a 3-bit address. A latch bit in the line-control register switches addresses 0 and 1 over to the two bytes of the baud divisor. The block holds the enable, line-control, modem-control, scratch and divisor registers. It keeps sticky line-error flags and builds change flags from four modem lines. It ranks the pending interrupt causes and presents the winner as an identification code.

The receive FIFO, transmitter and line-error logic around the block report status through level and pulse inputs. The block returns pop, push and flush strokes to them. Reads have side effects: reading the line-status, modem-status, receive-buffer or identification register clears the matching cause. The identification code is held steady for the whole of a read strobe. The interrupt pin is driven only while a modem-control bit allows it.

Top module: `uirq_host_regs`

## Requirements
- R1: Causes rank from highest to lowest as line error (code 6h), received data (4h) then receive timeout (Ch) at one level with data first, transmit empty (2h), modem change (0h). The code sits in identification bits 3:0, and bit 0 is 1 when nothing is pending (byte 01h).
- R2: Identification bits 7 and 6 both equal the FIFO-enable state. Bit 3 reads 0 while FIFO mode is off, and no receive timeout is recorded then.
- R3: While a read strobe on address 2 is held, the identification byte does not change, even if a higher cause arrives. The new code shows after the strobe ends.
- R4: Line-status byte: bit0 receive data present, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bit5 transmit holding empty, bit6 transmitter idle, bit7 FIFO mode with a parity, framing or break flag set. Bits 4:1 are sticky and clear at the start of a line-status read, and an error pulse in that same cycle is kept.
- R5: Received-data cause: in FIFO mode it follows the at-trigger input, otherwise the data-present input. A timeout pulse in FIFO mode raises the Ch cause until the next receive-buffer read (address 0, latch bit 0), which returns the FIFO head byte.
- R6: The transmit-empty cause sets when enable bit 1 rises while the holding register is empty, or on an empty event. It clears on a transmit write (address 0, latch bit 0) or on an identification read that showed code 2h.
- R7: In FIFO mode, a rise of the transmit-empty input is reported only at the next character-tick pulse. This applies unless the FIFO has held two bytes since the flag last set, or it is the first rise after FIFO mode was turned on. In those cases, and always in non-FIFO mode, the report is immediate.
- R8: Modem-status byte: bits 7:4 are carrier, ring, data-set-ready and clear-to-send. Bits 3:0 are their change flags, where ring (bit 2) sets only on a 1-to-0 change. All four flags clear when a modem-status read starts.
- R9: With line-control bit 7 set, addresses 0 and 1 read and write the low and high divisor bytes. Address 7 is a free read/write byte.
- R10: A write to address 2 with bit 0 set turns FIFO mode on and loads the trigger select from bits 7:6. The write flushes the FIFOs named by bits 1 and 2, or both FIFOs when the mode was off. With bit 0 clear, the write turns FIFO mode off, flushes both FIFOs and leaves the trigger select unchanged.
- R11: The interrupt pin is driven, and the drive flag is 1, only while modem-control bit 3 is 1. When driven, the pin is 1 exactly when some enabled cause is pending.
- R12: Enable-register bits 7:4 read back as 0. FIFO-control bit 3 has no effect.
- R13: After reset every register is 0 and the identification byte reads 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Block select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (may be held several cycles) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| rx_nonempty | input | 1 | Receive data present |
| rx_at_trig | input | 1 | Receive occupancy at or above trigger |
| rx_stall | input | 1 | Receive timeout pulse |
| rx_pop | output | 1 | One-cycle pop on receive-buffer read |
| tx_vacant | input | 1 | Transmit holding side empty |
| tx_pair | input | 1 | Transmit FIFO holds two or more bytes |
| char_tick | input | 1 | Pulse one character time minus a stop bit after the last load |
| tx_idle | input | 1 | Transmitter fully idle |
| tx_push | output | 1 | One-cycle push on transmit write |
| err_overrun | input | 1 | Overrun error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| brk_seen | input | 1 | Break detect pulse |
| ln_cts | input | 1 | Clear-to-send line |
| ln_dsr | input | 1 | Data-set-ready line |
| ln_ri | input | 1 | Ring line |
| ln_dcd | input | 1 | Carrier line |
| fifo_on | output | 1 | FIFO mode active |
| rx_trig_lvl | output | 2 | Receive trigger select |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| baud_div | output | 16 | Divisor value |
| line_ctl | output | 8 | Line-control register |
| modem_ctl | output | 5 | Modem-control register |
| irq | output | 1 | Interrupt pin, high-impedance when not driven |
| irq_drive | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach is the delayed transmit-empty report. It needs FIFO mode, a first rise that uses up the immediate-report allowance, and a second rise with no two-byte episode between them. The stimulus enables FIFO mode, toggles the transmit-empty input twice, and checks that the code stays 01h until the character tick. A third rise after a two-byte pulse must report at once. The frozen code is reached by holding a read strobe for four cycles and firing an overrun pulse in the middle of it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int REG_W  = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_IER  = 3'd1,
        A_IIR  = 3'd2,
        A_LCR  = 3'd3,
        A_MCR  = 3'd4,
        A_LSR  = 3'd5,
        A_MSR  = 3'd6,
        A_SCR  = 3'd7
    } reg_sel_e;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_TXEMPTY = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
        logic modem;
    } irq_req_t;

    // Fixed ranking of the causes; data wins over timeout at the same level.
    function automatic irq_id_e pick_id(irq_req_t r);
        if (r.line)         return ID_LINE;
        else if (r.rxdata)  return ID_RXDATA;
        else if (r.timeout) return ID_TIMEOUT;
        else if (r.txempty) return ID_TXEMPTY;
        else if (r.modem)   return ID_MODEM;
        else                return ID_NONE;
    endfunction

    function automatic logic [7:0] iir_byte(irq_id_e id, logic fifo_mode);
        logic [3:0] c;
        c = id;
        if (!fifo_mode) c[3] = 1'b0;
        return {fifo_mode, fifo_mode, 2'b00, c};
    endfunction

endpackage

// File: rtl/uirq_msr_delta.sv
module uirq_msr_delta #(
    parameter int N_LINES   = 4,
    parameter int TRAIL_IDX = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  logic               clr,
    output logic [N_LINES-1:0] delta
);
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] ev;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        if (g == TRAIL_IDX) begin : g_trail
            assign ev[g] = prev_q[g] & ~lines[g];
        end else begin : g_any
            assign ev[g] = prev_q[g] ^ lines[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= lines;
            delta  <= '0;
        end else begin
            prev_q <= lines;
            delta  <= (delta & ~{N_LINES{clr}}) | ev;
        end
    end
endmodule

// File: rtl/uirq_thre_delay.sv
module uirq_thre_delay (
    input  logic clk,
    input  logic rst,
    input  logic fifo_on,
    input  logic fifo_rise,
    input  logic vacant,
    input  logic pair,
    input  logic char_tick,
    output logic set_evt
);
    logic vac_q, wait_q, pair_q, first_q;
    logic rise, immediate, late;

    assign rise      = vacant & ~vac_q;
    assign immediate = rise & (~fifo_on | first_q | pair_q);
    assign late      = wait_q & char_tick & vacant;
    assign set_evt   = immediate | late;

    always_ff @(posedge clk) begin
        if (rst) begin
            vac_q   <= 1'b0;
            wait_q  <= 1'b0;
            pair_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            vac_q <= vacant;
            if (rise && !immediate)          wait_q <= 1'b1;
            else if (late || !vacant)        wait_q <= 1'b0;
            if (set_evt)                     pair_q <= 1'b0;
            else if (pair)                   pair_q <= 1'b1;
            if (fifo_rise)                   first_q <= 1'b1;
            else if (rise && fifo_on)        first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uirq_id_latch.sv
module uirq_id_latch import uirq_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  irq_req_t req,
    input  logic     hold,
    output logic     any,
    output irq_id_e  id_q
);
    assign any = |req;

    always_ff @(posedge clk) begin
        if (rst)        id_q <= ID_NONE;
        else if (!hold) id_q <= pick_id(req);
    end
endmodule

// File: rtl/uirq_host_regs.sv
module uirq_host_regs import uirq_pkg::*; #(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = SEL_W,
    parameter int TRIG_W = 2,
    parameter int MCR_W  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W-1:0]   rx_head,
    input  logic                rx_nonempty,
    input  logic                rx_at_trig,
    input  logic                rx_stall,
    output logic                rx_pop,
    input  logic                tx_vacant,
    input  logic                tx_pair,
    input  logic                char_tick,
    input  logic                tx_idle,
    output logic                tx_push,
    input  logic                err_overrun,
    input  logic                err_parity,
    input  logic                err_frame,
    input  logic                brk_seen,
    input  logic                ln_cts,
    input  logic                ln_dsr,
    input  logic                ln_ri,
    input  logic                ln_dcd,
    output logic                fifo_on,
    output logic [TRIG_W-1:0]   rx_trig_lvl,
    output logic                rx_flush,
    output logic                tx_flush,
    output logic [2*DATA_W-1:0] baud_div,
    output logic [DATA_W-1:0]   line_ctl,
    output logic [MCR_W-1:0]    modem_ctl,
    output logic                irq,
    output logic                irq_drive
);
    localparam int IER_W  = 4;
    localparam int ERR_W  = 4;
    localparam int LINE_N = 4;

    logic [DATA_W-1:0] div_lo_q, div_hi_q, lcr_q, scr_q;
    logic [IER_W-1:0]  ier_q;
    logic [MCR_W-1:0]  modem_ctl_q;
    logic [TRIG_W-1:0] trig_q;
    logic              fifo_q;
    logic [ERR_W-1:0]  lsr_err_q;
    logic              to_q, thre_q, rd_q;
    logic [LINE_N-1:0] modem_lines, msr_delta;

    logic wr_hit, rd_act, rd_start, dlab;
    logic thr_wr, ier_wr, fcr_wr, rbr_rd;
    logic iir_rd_act, iir_rd_start, lsr_rd_start, msr_rd_start;
    logic etbei_on, fifo_rise, thre_evt, irq_live;
    logic fcr_unused;
    irq_req_t req;
    irq_id_e  id_q;
    logic [DATA_W-1:0] lsr_byte;

    assign wr_hit       = bus_sel & bus_wr;
    assign rd_act       = bus_sel & bus_rd;
    assign rd_start     = rd_act & ~rd_q;
    assign dlab         = lcr_q[DATA_W-1];
    assign thr_wr       = wr_hit & (bus_addr == A_DATA) & ~dlab;
    assign ier_wr       = wr_hit & (bus_addr == A_IER) & ~dlab;
    assign fcr_wr       = wr_hit & (bus_addr == A_IIR);
    assign rbr_rd       = rd_start & (bus_addr == A_DATA) & ~dlab;
    assign iir_rd_act   = rd_act & (bus_addr == A_IIR);
    assign iir_rd_start = rd_start & (bus_addr == A_IIR);
    assign lsr_rd_start = rd_start & (bus_addr == A_LSR);
    assign msr_rd_start = rd_start & (bus_addr == A_MSR);
    assign etbei_on     = ier_wr & bus_wdata[1] & ~ier_q[1];
    assign fifo_rise    = fcr_wr & bus_wdata[0] & ~fifo_q;
    assign fcr_unused   = ^bus_wdata[5:3];
    assign modem_lines  = {ln_dcd, ln_ri, ln_dsr, ln_cts};

    assign rx_pop   = rbr_rd;
    assign tx_push  = thr_wr;
    assign fifo_on  = fifo_q;
    assign rx_trig_lvl = trig_q;
    assign baud_div = {div_hi_q, div_lo_q};
    assign line_ctl = lcr_q;
    assign modem_ctl = modem_ctl_q;

    // Host-written registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo_q    <= '0;
            div_hi_q    <= '0;
            lcr_q       <= '0;
            scr_q       <= '0;
            ier_q       <= '0;
            modem_ctl_q <= '0;
            rd_q        <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (wr_hit) begin
                unique case (bus_addr)
                    A_DATA: if (dlab) div_lo_q <= bus_wdata;
                    A_IER:  if (dlab) div_hi_q <= bus_wdata;
                            else      ier_q    <= bus_wdata[IER_W-1:0];
                    A_LCR:  lcr_q       <= bus_wdata;
                    A_MCR:  modem_ctl_q <= bus_wdata[MCR_W-1:0];
                    A_SCR:  scr_q       <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // FIFO control: bit 0 gates everything else in the same write.
    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_q   <= 1'b0;
            trig_q   <= '0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
            if (fcr_wr) begin
                if (bus_wdata[0]) begin
                    fifo_q   <= 1'b1;
                    trig_q   <= bus_wdata[DATA_W-1 -: TRIG_W];
                    rx_flush <= bus_wdata[1] | ~fifo_q;
                    tx_flush <= bus_wdata[2] | ~fifo_q;
                end else begin
                    fifo_q   <= 1'b0;
                    rx_flush <= 1'b1;
                    tx_flush <= 1'b1;
                end
            end
        end
    end

    // Sticky causes; a new event in a clearing cycle survives.
    always_ff @(posedge clk) begin
        if (rst) begin
            lsr_err_q <= '0;
            to_q      <= 1'b0;
            thre_q    <= 1'b0;
        end else begin
            lsr_err_q <= (lsr_err_q & ~{ERR_W{lsr_rd_start}})
                       | {brk_seen, err_frame, err_parity, err_overrun};
            if (!fifo_q)                to_q <= 1'b0;
            else if (rx_stall)          to_q <= 1'b1;
            else if (rbr_rd)            to_q <= 1'b0;
            if (thre_evt || (etbei_on && tx_vacant))
                thre_q <= 1'b1;
            else if (thr_wr || (iir_rd_start && id_q == ID_TXEMPTY))
                thre_q <= 1'b0;
        end
    end

    uirq_thre_delay u_thre (
        .clk       (clk),
        .rst       (rst),
        .fifo_on   (fifo_q),
        .fifo_rise (fifo_rise),
        .vacant    (tx_vacant),
        .pair      (tx_pair),
        .char_tick (char_tick),
        .set_evt   (thre_evt)
    );

    uirq_msr_delta #(.N_LINES(LINE_N), .TRAIL_IDX(2)) u_delta (
        .clk   (clk),
        .rst   (rst),
        .lines (modem_lines),
        .clr   (msr_rd_start),
        .delta (msr_delta)
    );

    always_comb begin
        req.line    = ier_q[2] & (|lsr_err_q);
        req.rxdata  = ier_q[0] & (fifo_q ? rx_at_trig : rx_nonempty);
        req.timeout = ier_q[0] & to_q;
        req.txempty = ier_q[1] & thre_q;
        req.modem   = ier_q[3] & (|msr_delta);
    end

    uirq_id_latch u_id (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .hold (iir_rd_act),
        .any  (irq_live),
        .id_q (id_q)
    );

    assign lsr_byte = {fifo_q & (|lsr_err_q[3:1]), tx_idle, tx_vacant,
                       lsr_err_q, rx_nonempty};

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = dlab ? div_lo_q : rx_head;
            A_IER:   bus_rdata = dlab ? div_hi_q : DATA_W'(ier_q);
            A_IIR:   bus_rdata = iir_byte(id_q, fifo_q);
            A_LCR:   bus_rdata = lcr_q;
            A_MCR:   bus_rdata = DATA_W'(modem_ctl_q);
            A_LSR:   bus_rdata = lsr_byte;
            A_MSR:   bus_rdata = {modem_lines, msr_delta};
            default: bus_rdata = scr_q;
        endcase
    end

    assign irq_drive = modem_ctl_q[3];
    assign irq       = irq_drive ? irq_live : 1'bz;
endmodule

// File: rtl/uirq_host_chk.sv
module uirq_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       iir_rd_act,
    input logic [3:0] id_q,
    input logic [4:0] req,
    input logic       lsr_rd_start,
    input logic       err_parity,
    input logic [3:0] lsr_err_q,
    input logic       msr_rd_start,
    input logic [3:0] modem_lines,
    input logic [3:0] msr_delta,
    input logic       fcr_wr,
    input logic       wdata0,
    input logic       fifo_q,
    input logic       irq_drive,
    input logic       irq
);
    p_prio_line_r1: assert property (@(posedge clk) disable iff (rst)
        (req[4] && !iir_rd_act) |=> (id_q == 4'h6));

    p_iir_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (iir_rd_act && $past(iir_rd_act)) |-> $stable(id_q));

    p_err_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd_start && err_parity) |=> lsr_err_q[1]);

    p_delta_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (msr_rd_start && $stable(modem_lines)) |=> (msr_delta == 4'h0));

    p_fifo_enable_r10: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && wdata0) |=> fifo_q);

    p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_drive && (req != 5'd0)) |-> (irq == 1'b1));
endmodule

bind uirq_host_regs uirq_host_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .iir_rd_act   (iir_rd_act),
    .id_q         (id_q),
    .req          (req),
    .lsr_rd_start (lsr_rd_start),
    .err_parity   (err_parity),
    .lsr_err_q    (lsr_err_q),
    .msr_rd_start (msr_rd_start),
    .modem_lines  (modem_lines),
    .msr_delta    (msr_delta),
    .fcr_wr       (fcr_wr),
    .wdata0       (bus_wdata[0]),
    .fifo_q       (fifo_q),
    .irq_drive    (irq_drive),
    .irq          (irq)
);

// File: tb/test_uirq_host_regs.sv
module test_uirq_host_regs;
    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [7:0] rx_head = 0;
    logic rx_nonempty = 0, rx_at_trig = 0, rx_stall = 0, rx_pop;
    logic tx_vacant = 1, tx_pair = 0, char_tick = 0, tx_idle = 1, tx_push;
    logic err_overrun = 0, err_parity = 0, err_frame = 0, brk_seen = 0;
    logic ln_cts = 0, ln_dsr = 0, ln_ri = 0, ln_dcd = 0;
    logic fifo_on, rx_flush, tx_flush, irq, irq_drive;
    logic [1:0]  rx_trig_lvl;
    logic [15:0] baud_div;
    logic [7:0]  line_ctl;
    logic [4:0]  modem_ctl;

    uirq_host_regs i_uirq_host_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_head(rx_head), .rx_nonempty(rx_nonempty), .rx_at_trig(rx_at_trig),
        .rx_stall(rx_stall), .rx_pop(rx_pop), .tx_vacant(tx_vacant), .tx_pair(tx_pair),
        .char_tick(char_tick), .tx_idle(tx_idle), .tx_push(tx_push),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
        .brk_seen(brk_seen), .ln_cts(ln_cts), .ln_dsr(ln_dsr), .ln_ri(ln_ri),
        .ln_dcd(ln_dcd), .fifo_on(fifo_on), .rx_trig_lvl(rx_trig_lvl),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .baud_div(baud_div),
        .line_ctl(line_ctl), .modem_ctl(modem_ctl), .irq(irq), .irq_drive(irq_drive)
    );

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sb[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Monitor: every read cycle pops one expected byte.
    always @(negedge clk) begin
        if (!rst && bus_sel && bus_rd) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: read at addr %0d with no expectation, actual %02h expected none",
                         bus_addr, bus_rdata);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s: addr %0d actual %02h expected %02h",
                             it.tag, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        it.tag = tag; it.exp = e;
        sb.push_back(it);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic push_exp(input logic [7:0] e, input string tag);
        sb_item_t it;
        it.tag = tag; it.exp = e;
        sb.push_back(it);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 0;
        tick(2);

        // R13 reset state
        rd(3'd1, 8'h00, "R13 enable reg");
        rd(3'd2, 8'h01, "R13 ident");
        rd(3'd3, 8'h00, "R13 line ctl");
        rd(3'd5, 8'h60, "R13 line status");
        rd(3'd6, 8'h00, "R13 modem status");
        check_val("R13 fifo off", fifo_on, 0);
        check_val("R11 pin not driven after reset", irq_drive, 0);

        // R9 divisor latch and scratch
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, 8'h34, "R9 divisor low");
        rd(3'd1, 8'h12, "R9 divisor high");
        check_val("R9 divisor port", baud_div, 16'h1234);
        wr(3'd3, 8'h03);
        rd(3'd3, 8'h03, "R9 line ctl");
        rd(3'd1, 8'h00, "R9 enable reg behind latch");
        wr(3'd7, 8'hA5);
        rd(3'd7, 8'hA5, "R9 scratch");

        // R12 enable upper bits
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h0F, "R12 enable readback");
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h77);

        // R11 / R6 transmit-empty cause
        wr(3'd4, 8'h08);
        check_val("R11 pin driven", irq_drive, 1);
        check_val("R11 pin idle", irq, 0);
        wr(3'd1, 8'h02);
        check_val("R11 pin raised by tx empty", irq, 1);
        rd(3'd2, 8'h02, "R6 tx empty code");
        rd(3'd2, 8'h01, "R6 cleared by ident read");
        check_val("R11 pin low after clear", irq, 0);
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        check_val("R6 set again", irq, 1);
        wr(3'd0, 8'h55);
        check_val("R6 cleared by tx write", irq, 0);
        rd(3'd2, 8'h01, "R6 ident after tx write");

        // R1 priority ladder
        wr(3'd1, 8'h0F);
        @(posedge clk); #1 ln_cts = 1;
        tick(2);
        rd(3'd2, 8'h00, "R1 modem code");
        wr(3'd1, 8'h0D);
        wr(3'd1, 8'h0F);
        @(posedge clk); #1 rx_nonempty = 1;
        tick(2);
        rd(3'd2, 8'h04, "R1 data over tx empty");
        @(posedge clk); #1 err_parity = 1;
        @(posedge clk); #1 err_parity = 0;
        tick(1);
        rd(3'd2, 8'h06, "R1 line over data");
        rd(3'd5, 8'h65, "R4 parity in line status");
        rd(3'd2, 8'h04, "R4 line cleared by read");
        @(posedge clk); #1 rx_nonempty = 0;
        tick(2);
        rd(3'd2, 8'h02, "R1 tx empty over modem");
        rd(3'd2, 8'h00, "R1 modem last");
        rd(3'd6, 8'h11, "R8 cts change");
        rd(3'd2, 8'h01, "R8 modem cleared");

        // R4 error arriving in the clearing read cycle
        @(posedge clk); #1;
        push_exp(8'h60, "R4 read before framing");
        bus_sel = 1; bus_rd = 1; bus_addr = 3'd5; err_frame = 1;
        @(posedge clk); #1;
        bus_sel = 0; bus_rd = 0; err_frame = 0;
        rd(3'd5, 8'h68, "R4 framing kept");
        rd(3'd5, 8'h60, "R4 framing cleared");

        // R8 ring trailing edge and pulses
        @(posedge clk); #1 ln_ri = 1;
        tick(2);
        rd(3'd6, 8'h50, "R8 ring rise no flag");
        @(posedge clk); #1 ln_ri = 0;
        tick(2);
        rd(3'd6, 8'h14, "R8 ring fall flag");
        rd(3'd6, 8'h10, "R8 flags cleared");
        @(posedge clk); #1 ln_dsr = 1;
        @(posedge clk); #1 ln_dsr = 0;
        tick(1);
        rd(3'd6, 8'h12, "R8 dsr pulse flag");
        rd(3'd2, 8'h01, "R8 ident idle");

        // R2 timeout ignored in non-FIFO mode
        @(posedge clk); #1 rx_stall = 1;
        @(posedge clk); #1 rx_stall = 0;
        tick(2);
        rd(3'd2, 8'h01, "R2 no timeout without fifo");

        // R10 FIFO control
        wr(3'd2, 8'hC1);
        check_val("R10 fifo on", fifo_on, 1);
        check_val("R10 trigger", rx_trig_lvl, 3);
        rd(3'd2, 8'hC1, "R2 fifo bits");
        wr(3'd2, 8'h80);
        check_val("R10 flush both", {rx_flush, tx_flush}, 2'b11);
        check_val("R10 fifo off", fifo_on, 0);
        check_val("R10 trigger kept", rx_trig_lvl, 3);
        wr(3'd2, 8'h41);
        wr(3'd2, 8'h49);
        check_val("R12 dma bit no effect fifo", fifo_on, 1);
        check_val("R12 dma bit no effect trigger", rx_trig_lvl, 1);

        // R5 received data and timeout in FIFO mode
        wr(3'd1, 8'h01);
        @(posedge clk); #1 rx_nonempty = 1;
        tick(2);
        rd(3'd2, 8'hC1, "R5 below trigger");
        @(posedge clk); #1 rx_at_trig = 1;
        tick(2);
        rd(3'd2, 8'hC4, "R5 at trigger");
        @(posedge clk); #1 rx_at_trig = 0;
        tick(2);
        rd(3'd2, 8'hC1, "R5 dropped below");
        @(posedge clk); #1 rx_stall = 1;
        @(posedge clk); #1 rx_stall = 0;
        tick(1);
        rd(3'd2, 8'hCC, "R5 timeout code");
        rx_head = 8'h5A;
        rd(3'd0, 8'h5A, "R5 buffer read");
        rd(3'd2, 8'hC1, "R5 timeout cleared");
        @(posedge clk); #1 rx_nonempty = 0;

        // R3 freeze during held read
        wr(3'd1, 8'h05);
        rd(3'd2, 8'hC1, "R3 before hold");
        @(posedge clk); #1;
        push_exp(8'hC1, "R3 held 1");
        bus_sel = 1; bus_rd = 1; bus_addr = 3'd2;
        @(posedge clk); #1;
        push_exp(8'hC1, "R3 held 2");
        err_overrun = 1;
        @(posedge clk); #1;
        push_exp(8'hC1, "R3 held 3");
        err_overrun = 0;
        @(posedge clk); #1;
        push_exp(8'hC1, "R3 held 4");
        @(posedge clk); #1;
        bus_sel = 0; bus_rd = 0;
        rd(3'd2, 8'hC6, "R3 shown after hold");
        rd(3'd5, 8'h62, "R4 overrun status");
        rd(3'd2, 8'hC1, "R3 line cleared");

        // R7 delayed transmit-empty report
        wr(3'd1, 8'h02);
        rd(3'd2, 8'hC2, "R6 enable sets");
        rd(3'd2, 8'hC1, "R6 cleared");
        @(posedge clk); #1 tx_vacant = 0;
        @(posedge clk); #1 tx_vacant = 1;
        tick(2);
        rd(3'd2, 8'hC2, "R7 first after enable immediate");
        rd(3'd2, 8'hC1, "R7 cleared");
        @(posedge clk); #1 tx_vacant = 0;
        @(posedge clk); #1 tx_vacant = 1;
        tick(3);
        rd(3'd2, 8'hC1, "R7 held until tick");
        @(posedge clk); #1 char_tick = 1;
        @(posedge clk); #1 char_tick = 0;
        tick(1);
        rd(3'd2, 8'hC2, "R7 reported at tick");
        rd(3'd2, 8'hC1, "R7 cleared again");
        @(posedge clk); #1 tx_vacant = 0;
        @(posedge clk); #1 tx_pair = 1;
        @(posedge clk); #1 tx_pair = 0;
        @(posedge clk); #1 tx_vacant = 1;
        tick(2);
        rd(3'd2, 8'hC2, "R7 immediate after pair");

        wr(3'd4, 8'h00);
        check_val("R11 pin released", irq_drive, 0);
        tick(2);
        check_val("scoreboard drained", sb.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule